// File: doc/BRIEF.md
# Stochastic Tri-State Neighbourhood Weight Updater

This block performs the training-side weight update of a binary self-organizing map whose weights are tri-state symbols: zero, one or don't-care. It acts after a winner neuron has been chosen for one input vector. It works out which neurons on the one-dimensional map lie close enough to the winner. The radius of that window shrinks in four steps across the iteration budget. The block then walks through every symbol of those neurons, one bit position per cycle. It reads each stored symbol, moves it one step toward the input bit, and writes back only the symbols that change.

Learning is stochastic rather than arithmetic. A pseudo-random value is drawn from an internal fixed table at an address derived from the iteration count. It is compared against an externally supplied update threshold, which falls over training. If the random value does not exceed the threshold, no symbol changes in that presentation. The weight store sits outside the block and is reached through a read port with one cycle of latency and a separate write port.

Top module: `bsom_wupdate`

## Requirements
- R1: Symbols are coded 2'b00 = zero, 2'b01 = one, 2'b10 = don't-care; a stored 2'b11 reads as don't-care. A zero or one that differs from the input bit becomes don't-care. A don't-care becomes the input bit (2'b00 or 2'b01). A zero or one equal to the input bit is left unchanged and not written.
- R2: Symbols change only when the drawn table value is strictly greater than `upd_thresh`. When it is equal or smaller, the presentation issues no write.
- R3: The random table holds 2000 ten-bit entries, with entry i = (i*373 + 91) mod 1024. It is addressed by `iter` when `iter` < 2000, otherwise by `iter[9:0]`.
- R4: The radius is 4 when 4*iter <= budget, 3 when 4*iter <= 2*budget, 2 when 4*iter <= 3*budget, and 1 otherwise. With a budget of 100, iteration 25 uses 4 and iteration 26 uses 3.
- R5: The affected neurons are those whose index lies within the radius of `winner`, clipped to the range 0 to N_NEURONS-1. No other neuron is written.
- R6: `start` is accepted only while `busy` is low, and all inputs are sampled in that cycle. A `start` while busy is ignored, as are changes to `winner`, `iter`, `budget`, `upd_thresh` or `x_vec` during a run.
- R7: Reads visit the affected neurons in ascending order and, within each neuron, bits 0 to N_BITS-1, one per cycle. `wt_rd_data` is taken one cycle after the read. The matching write, if any, appears on the cycle after that.
- R8: `done` rises after the last write of a run, stays high until the next accepted `start`, and is never high together with `busy`.
- R9: After reset `busy`, `done`, `wt_rd_en` and `wt_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Winner is known; begin an update |
| winner | input | IDX_W | Index of the winning neuron |
| iter | input | IT_W | Current iteration number |
| budget | input | IT_W | Total iteration budget |
| upd_thresh | input | RND_W | Update threshold |
| x_vec | input | N_BITS | Input vector bits |
| busy | output | 1 | Update run in progress |
| done | output | 1 | Last run finished |
| wt_rd_en | output | 1 | Weight read request |
| wt_rd_neuron | output | IDX_W | Neuron of the read |
| wt_rd_bit | output | BIT_W | Bit position of the read |
| wt_rd_data | input | 2 | Symbol read, one cycle after the request |
| wt_wr_en | output | 1 | Weight write strobe |
| wt_wr_neuron | output | IDX_W | Neuron of the write |
| wt_wr_bit | output | BIT_W | Bit position of the write |
| wt_wr_data | output | 2 | Symbol written |

## Verification
The stored weights start as a mix of all four codes, including 2'b11. Presentations then use input vectors of alternating, all-ones and sparse bits, so each cell of the transition rule is hit with both input values. Winners in the middle and at both ends of the map separate the correct clipping of the window from an unclipped or shifted one. Iterations 25 and 26 separate the radius steps, and iterations of 60, 90 and 2100 reach the lower radii and the folded table address. A threshold equal to the drawn value tells a strict comparison apart from a non-strict one. A start pulse with a different winner and vector in the middle of a run shows whether inputs leak into a run already under way.

// File: rtl/bsom_pkg.sv
package bsom_pkg;

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_ONE  = 2'b01;
  localparam logic [1:0] SYM_DC   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SCAN,
    ST_DRAIN
  } upd_state_e;

  typedef struct packed {
    logic       chg;
    logic [1:0] sym;
  } sym_step_t;

  // One step of the tri-state rule; bit 1 set means don't-care (covers 2'b11).
  function automatic sym_step_t step_symbol(input logic [1:0] w, input logic x);
    sym_step_t r;
    if (w[1]) begin
      r.chg = 1'b1;
      r.sym = {1'b0, x};
    end else if (w[0] != x) begin
      r.chg = 1'b1;
      r.sym = SYM_DC;
    end else begin
      r.chg = 1'b0;
      r.sym = w;
    end
    return r;
  endfunction

endpackage

// File: rtl/bsom_rand_rom.sv
module bsom_rand_rom #(
  parameter int DEPTH = 2000,
  parameter int DW    = 10,
  parameter int AW    = 11,
  parameter int MULT  = 373,
  parameter int OFFS  = 91
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic [DW-1:0] table_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      table_q[i] = DW'((i * MULT + OFFS) % (1 << DW));
    end
  end

  always_ff @(posedge clk) begin
    data <= table_q[addr];
  end

endmodule

// File: rtl/bsom_nbr_range.sv
module bsom_nbr_range #(
  parameter int N_NEURONS = 16,
  parameter int IT_W      = 16,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0] winner,
  input  logic [IT_W-1:0]  iter,
  input  logic [IT_W-1:0]  budget,
  output logic [IDX_W-1:0] lo,
  output logic [IDX_W-1:0] hi
);

  localparam int CW = IT_W + 2;
  localparam int EW = IDX_W + 3;
  localparam logic [EW-1:0] LAST = EW'(N_NEURONS - 1);

  logic [CW-1:0] it4, q1, q2, q3;
  logic [2:0]    radius;
  logic [EW-1:0] we, re, lo_e, hi_e, sum_e;

  always_comb begin
    it4 = {iter, 2'b00};
    q1  = CW'(budget);
    q2  = q1 << 1;
    q3  = q1 + q2;
    if (it4 <= q1)      radius = 3'd4;
    else if (it4 <= q2) radius = 3'd3;
    else if (it4 <= q3) radius = 3'd2;
    else                radius = 3'd1;
  end

  always_comb begin
    we    = EW'(winner);
    re    = EW'(radius);
    sum_e = we + re;
    lo_e  = (we >= re) ? (we - re) : '0;
    hi_e  = (sum_e > LAST) ? LAST : sum_e;
    lo    = IDX_W'(lo_e);
    hi    = IDX_W'(hi_e);
  end

endmodule

// File: rtl/bsom_wupdate.sv
module bsom_wupdate
  import bsom_pkg::*;
#(
  parameter int N_NEURONS = 16,
  parameter int N_BITS    = 32,
  parameter int IT_W      = 16,
  parameter int RND_W     = 10,
  parameter int TABLE_LEN = 2000,
  parameter int FOLD_BITS = 10,
  parameter int IDX_W     = $clog2(N_NEURONS),
  parameter int BIT_W     = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  winner,
  input  logic [IT_W-1:0]   iter,
  input  logic [IT_W-1:0]   budget,
  input  logic [RND_W-1:0]  upd_thresh,
  input  logic [N_BITS-1:0] x_vec,
  output logic              busy,
  output logic              done,
  output logic              wt_rd_en,
  output logic [IDX_W-1:0]  wt_rd_neuron,
  output logic [BIT_W-1:0]  wt_rd_bit,
  input  logic [1:0]        wt_rd_data,
  output logic              wt_wr_en,
  output logic [IDX_W-1:0]  wt_wr_neuron,
  output logic [BIT_W-1:0]  wt_wr_bit,
  output logic [1:0]        wt_wr_data
);

  localparam int TBL_AW = $clog2(TABLE_LEN);
  localparam logic [IT_W-1:0]  TBL_LEN_V = IT_W'(TABLE_LEN);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(N_BITS - 1);

  upd_state_e        state_q;
  logic [IDX_W-1:0]  win_q;
  logic [IT_W-1:0]   iter_q, bud_q;
  logic [RND_W-1:0]  thr_q;
  logic [N_BITS-1:0] x_q;

  logic [IDX_W-1:0]  lo_w, hi_w;
  logic [TBL_AW-1:0] tbl_idx;
  logic [RND_W-1:0]  rnd;
  logic              gate;

  logic              rd_en_q;
  logic [IDX_W-1:0]  rd_n_q;
  logic [BIT_W-1:0]  rd_b_q;
  logic              p_valid_q;
  logic [IDX_W-1:0]  p_n_q;
  logic [BIT_W-1:0]  p_b_q;
  logic              wr_en_q;
  logic [IDX_W-1:0]  wr_n_q;
  logic [BIT_W-1:0]  wr_b_q;
  logic [1:0]        wr_d_q;
  logic              done_q;
  sym_step_t         step;

  bsom_nbr_range #(
    .N_NEURONS(N_NEURONS), .IT_W(IT_W), .IDX_W(IDX_W)
  ) u_range (
    .winner(win_q), .iter(iter_q), .budget(bud_q), .lo(lo_w), .hi(hi_w)
  );

  always_comb begin
    if (iter_q < TBL_LEN_V) tbl_idx = TBL_AW'(iter_q);
    else                    tbl_idx = TBL_AW'(iter_q[FOLD_BITS-1:0]);
  end

  bsom_rand_rom #(
    .DEPTH(TABLE_LEN), .DW(RND_W), .AW(TBL_AW)
  ) u_rom (
    .clk(clk), .addr(tbl_idx), .data(rnd)
  );

  assign gate = (rnd > thr_q);
  assign step = step_symbol(wt_rd_data, x_q[p_b_q]);

  // Control and read address generation
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      iter_q  <= '0;
      bud_q   <= '0;
      thr_q   <= '0;
      x_q     <= '0;
      rd_en_q <= 1'b0;
      rd_n_q  <= '0;
      rd_b_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            win_q   <= winner;
            iter_q  <= iter;
            bud_q   <= budget;
            thr_q   <= upd_thresh;
            x_q     <= x_vec;
            done_q  <= 1'b0;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          rd_en_q <= 1'b1;
          rd_n_q  <= lo_w;
          rd_b_q  <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (rd_b_q == LAST_BIT) begin
            rd_b_q <= '0;
            if (rd_n_q == hi_w) begin
              rd_en_q <= 1'b0;
              state_q <= ST_DRAIN;
            end else begin
              rd_n_q <= rd_n_q + 1'b1;
            end
          end else begin
            rd_b_q <= rd_b_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (!p_valid_q) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Read-data stage and write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid_q <= 1'b0;
      p_n_q     <= '0;
      p_b_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_n_q    <= '0;
      wr_b_q    <= '0;
      wr_d_q    <= '0;
    end else begin
      p_valid_q <= rd_en_q;
      p_n_q     <= rd_n_q;
      p_b_q     <= rd_b_q;
      wr_en_q   <= p_valid_q && gate && step.chg;
      wr_n_q    <= p_n_q;
      wr_b_q    <= p_b_q;
      wr_d_q    <= step.sym;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign wt_rd_en     = rd_en_q;
  assign wt_rd_neuron = rd_n_q;
  assign wt_rd_bit    = rd_b_q;
  assign wt_wr_en     = wr_en_q;
  assign wt_wr_neuron = wr_n_q;
  assign wt_wr_bit    = wr_b_q;
  assign wt_wr_data   = wr_d_q;

  // R7: every write answers a read whose data was taken one cycle earlier
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
    wt_wr_en |-> $past(p_valid_q));

  // R2: no write unless the table value beats the threshold
  a_r2_write_needs_gate: assert property (@(posedge clk) disable iff (rst)
    wt_wr_en |-> (rnd > thr_q));

  // R1: written symbols are always legal codes
  a_r1_legal_symbol: assert property (@(posedge clk) disable iff (rst)
    wt_wr_en |-> (wt_wr_data != 2'b11));

  // R5: writes stay inside the clipped neighbourhood
  a_r5_write_in_window: assert property (@(posedge clk) disable iff (rst)
    wt_wr_en |-> (wt_wr_neuron >= lo_w && wt_wr_neuron <= hi_w));

  // R8: done and busy never overlap
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: reads never run while the block is idle
  a_r7_read_only_busy: assert property (@(posedge clk) disable iff (rst)
    wt_rd_en |-> busy);

endmodule

// File: tb/bsom_wupdate_tb_top.sv
module bsom_wupdate_tb_top;

  localparam int NN = 16;
  localparam int NB = 32;
  localparam int IW = 4;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [IW-1:0] winner = '0;
  logic [15:0]   iter = '0;
  logic [15:0]   budget = '0;
  logic [9:0]    upd_thresh = '0;
  logic [NB-1:0] x_vec = '0;
  logic          busy, done;
  logic          wt_rd_en, wt_wr_en;
  logic [IW-1:0] wt_rd_neuron, wt_wr_neuron;
  logic [BW-1:0] wt_rd_bit, wt_wr_bit;
  logic [1:0]    wt_rd_data = '0;
  logic [1:0]    wt_wr_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int reads  = 0;

  logic [1:0] mem  [NN][NB];
  logic [1:0] emem [NN][NB];
  logic [10:0] exp_q [$];   // {neuron, bit, symbol}

  always #5 clk = ~clk;

  bsom_wupdate dut_i (
    .clk(clk), .rst(rst), .start(start), .winner(winner), .iter(iter),
    .budget(budget), .upd_thresh(upd_thresh), .x_vec(x_vec),
    .busy(busy), .done(done),
    .wt_rd_en(wt_rd_en), .wt_rd_neuron(wt_rd_neuron), .wt_rd_bit(wt_rd_bit),
    .wt_rd_data(wt_rd_data),
    .wt_wr_en(wt_wr_en), .wt_wr_neuron(wt_wr_neuron), .wt_wr_bit(wt_wr_bit),
    .wt_wr_data(wt_wr_data)
  );

  // Weight store model: registered read, write on strobe
  always @(posedge clk) begin
    if (wt_rd_en) wt_rd_data <= mem[wt_rd_neuron][wt_rd_bit];
    if (wt_wr_en) mem[wt_wr_neuron][wt_wr_bit] <= wt_wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pops expected writes and compares
  always @(negedge clk) begin
    cycles++;
    if (!rst && wt_rd_en) reads++;
    if (!rst && wt_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R5 unexpected write",
              {wt_wr_neuron, wt_wr_bit, wt_wr_data}, -1);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        check({wt_wr_neuron, wt_wr_bit, wt_wr_data} == e, "R1/R7 write item",
              {wt_wr_neuron, wt_wr_bit, wt_wr_data}, e);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_rnd(input int it);   // R3
    int idx;
    idx = (it < 2000) ? it : (it % 1024);
    return (idx * 373 + 91) % 1024;
  endfunction

  function automatic int exp_radius(input int it, input int b);   // R4
    if (4 * it <= b)     return 4;
    if (4 * it <= 2 * b) return 3;
    if (4 * it <= 3 * b) return 2;
    return 1;
  endfunction

  // Driver: builds expected writes, then runs one presentation
  task automatic run_case(input int w, input int it, input int b, input int thr,
                          input logic [NB-1:0] xv, input bit poke_busy, input string tag);
    int r, lo, hi, nrd, t;
    bit g;
    r  = exp_radius(it, b);
    lo = (w - r < 0) ? 0 : w - r;
    hi = (w + r > NN - 1) ? NN - 1 : w + r;
    g  = (exp_rnd(it) > thr);
    for (int n = lo; n <= hi; n++) begin
      for (int k = 0; k < NB; k++) begin
        logic [1:0] s, ns;
        s = emem[n][k];
        if (s[1])               ns = {1'b0, xv[k]};
        else if (s[0] != xv[k]) ns = 2'b10;
        else                    ns = s;
        if (g && ns != s) begin
          exp_q.push_back({4'(n), 5'(k), ns});
          emem[n][k] = ns;
        end
      end
    end
    reads = 0;
    @(negedge clk);
    winner = IW'(w); iter = 16'(it); budget = 16'(b);
    upd_thresh = 10'(thr); x_vec = xv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    winner = ~winner; x_vec = ~xv; upd_thresh = 10'd1023;   // R6: changes during a run
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; winner = IW'((w + 8) % NN);
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    nrd = (hi - lo + 1) * NB;
    check(done && !busy, {"R8 done ", tag}, int'(done), 1);
    check(exp_q.size() == 0, {"R2/R7 missing writes ", tag}, exp_q.size(), 0);
    check(reads == nrd, {"R5/R7 read count ", tag}, reads, nrd);
    begin
      int bad;
      bad = 0;
      for (int n = 0; n < NN; n++)
        for (int k = 0; k < NB; k++)
          if (mem[n][k] != emem[n][k]) bad++;
      check(bad == 0, {"R1/R5 store contents ", tag}, bad, 0);
    end
    exp_q.delete();
  endtask

  initial begin
    for (int n = 0; n < NN; n++)
      for (int k = 0; k < NB; k++) begin
        mem[n][k]  = 2'((n * 7 + k * 3) % 4);
        emem[n][k] = 2'((n * 7 + k * 3) % 4);
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(!busy && !done && !wt_rd_en && !wt_wr_en, "R9 reset outputs",
          {busy, done, wt_rd_en, wt_wr_en}, 0);

    // R1 R4 R5: mid-map winner, radius 4, table value 749 > 500
    run_case(5, 10, 100, 500, 32'hAAAA_5555, 1'b0, "mid r4");
    // R2: threshold equal to table value 749, no writes
    run_case(5, 10, 100, 749, 32'hFFFF_0000, 1'b0, "gate equal");
    // R4 boundary: iteration 25 keeps radius 4
    run_case(8, 25, 100, 0, 32'hFFFF_FFFF, 1'b0, "iter25");
    // R4 boundary: iteration 26 drops to radius 3, R5 clipped at low end
    run_case(0, 26, 100, 0, 32'h0F0F_0F0F, 1'b0, "iter26 low clip");
    // R4: third quarter radius 2, R5 clipped at high end (967 > 900)
    run_case(15, 60, 100, 900, 32'h1248_8421, 1'b0, "r2 high clip");
    // R4: last quarter radius 1; R6: start while busy ignored
    run_case(7, 90, 100, 100, 32'h0000_0001, 1'b1, "r1 poke");
    // R3: iteration past the table folds to low 10 bits (value 31 > 20)
    run_case(9, 2100, 3000, 20, 32'hC3C3_3C3C, 1'b0, "fold");
    // R2: below-threshold at folded address (31 <= 40)
    run_case(9, 2100, 3000, 40, 32'h0000_0000, 1'b0, "fold gated");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule